// File: doc/BRIEF.md
# Segmented Carry-Select Adder

This block adds two 32-bit unsigned operands and a carry-in without any clock. The word is cut into four slices of 4, 4, 8 and 16 bits, from the least significant end upward. The bottom slice is a true ripple adder fed by the real carry-in.

Each higher slice is built twice in parallel. One copy assumes an incoming carry of zero and the other assumes one. The real carry that arrives from below steers a multiplexer, and that multiplexer picks the result of one copy. The carry each slice selects then drives the select of the next slice. The longest path after the bottom slice is therefore a short chain of muxes and does not grow bit by bit.

Besides the sum and the final carry-out, the block exposes the carry that enters the most significant bit. A surrounding datapath can XOR that carry with the carry-out to obtain signed overflow.

Top module: `csa32_adder`

## Requirements
- R1: `{carry_out, sum_out}` equals `op_a + op_b + carry_in` computed as a 33-bit unsigned value, for every input combination.
- R2: `sum_out[3:0]` equals the low 4 bits of `op_a[3:0] + op_b[3:0] + carry_in`. No bit above bit 3 influences these four bits.
- R3: A carry produced by bits [3:0] propagates into bit 4. With `op_a = 32'h0000_000F`, `op_b = 0` and `carry_in = 1`, the sum is `32'h0000_0010`.
- R4: A carry produced by bits [7:0] propagates into bit 8. With `op_a = 32'h0000_00FF`, `op_b = 0` and `carry_in = 1`, the sum is `32'h0000_0100`.
- R5: A carry produced by bits [15:0] propagates into bit 16. With `op_a = 32'h0000_FFFF`, `op_b = 0` and `carry_in = 1`, the sum is `32'h0001_0000`.
- R6: `carry_out` is 1 exactly when the true sum exceeds `2^32 - 1`. All-ones plus a carry-in of 1 gives `sum_out = 0` and `carry_out = 1`.
- R7: `carry_into_msb` equals bit 31 of `op_a[30:0] + op_b[30:0] + carry_in`. `carry_into_msb ^ carry_out` is 1 exactly when the operands, read as two's-complement values, overflow.
- R8: The outputs are a pure function of the present inputs. They are valid in the same cycle the inputs change, and no earlier input affects them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First addend |
| op_b | input | 32 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 32 | Sum, modulo 2^32 |
| carry_out | output | 1 | Carry out of bit 31 |
| carry_into_msb | output | 1 | Carry into bit 31, for overflow |

## Verification
The bottom slice is swept exhaustively over all 4-bit operand pairs with both carry-in values, with random upper bits riding along. This separates a wrong ripple cell from a correct one and shows that the upper bits cannot leak into the low nibble.

Walking runs of ones plus one, along with all-ones plus each carry-in, force a carry across each slice boundary. Any swapped mux leg or a select taken from the wrong slice then shows up as a wrong sum or carry-out.

Sign-boundary pairs such as `7FFF_FFFF + 1` and `8000_0000 + 8000_0000` separate the carry into the top bit from the carry out of it. A broad random sweep covers mixed carry patterns in every slice at once.

// File: rtl/csa_pkg.sv
package csa_pkg;
    localparam int unsigned NSEG = 4;

    typedef int unsigned seg_w_t [NSEG];

    // Bit offset of the lowest bit of slice idx.
    function automatic int unsigned seg_lo(seg_w_t w, int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < NSEG; k++) begin
            if (k < idx) acc = acc + w[k];
        end
        return acc;
    endfunction

    function automatic int unsigned seg_total(seg_w_t w);
        return seg_lo(w, NSEG);
    endfunction
endpackage

// File: rtl/csa_ripple_seg.sv
module csa_ripple_seg #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] s,
    output logic         cout,
    output logic         cmsb
);
    logic [W-1:0] s_d;
    logic         c_d;
    logic         cmsb_d;

    always_comb begin
        c_d    = cin;
        cmsb_d = 1'b0;
        s_d    = '0;
        for (int i = 0; i < int'(W); i++) begin
            if (i == int'(W) - 1) cmsb_d = c_d;
            s_d[i] = a[i] ^ b[i] ^ c_d;
            c_d    = (a[i] & b[i]) | (c_d & (a[i] ^ b[i]));
        end
    end

    assign s    = s_d;
    assign cout = c_d;
    assign cmsb = cmsb_d;
endmodule

// File: rtl/csa_select_seg.sv
module csa_select_seg #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel,
    output logic [W-1:0] s,
    output logic         cout,
    output logic         cmsb
);
    logic [W-1:0] s0_d, s1_d;
    logic         c0_d, c1_d;
    logic         m0_d, m1_d;

    // Speculative copy assuming no carry arrives.
    csa_ripple_seg #(.W(W)) u_plain (
        .a(a), .b(b), .cin(1'b0), .s(s0_d), .cout(c0_d), .cmsb(m0_d)
    );

    // Speculative copy assuming a carry arrives.
    csa_ripple_seg #(.W(W)) u_plus1 (
        .a(a), .b(b), .cin(1'b1), .s(s1_d), .cout(c1_d), .cmsb(m1_d)
    );

    always_comb begin
        if (sel) begin
            s    = s1_d;
            cout = c1_d;
            cmsb = m1_d;
        end else begin
            s    = s0_d;
            cout = c0_d;
            cmsb = m0_d;
        end
    end
endmodule

// File: rtl/csa32_adder.sv
module csa32_adder #(
    parameter csa_pkg::seg_w_t SEG_W = '{4, 4, 8, 16},
    parameter int unsigned     WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             carry_into_msb
);
    import csa_pkg::*;

    localparam int unsigned W0 = SEG_W[0];

    logic [NSEG:0]  carry_d;
    logic [NSEG-1:0] msb_d;
    logic [WIDTH-1:0] sum_d;

    assign carry_d[0] = carry_in;

    // Bottom slice: true ripple from the real carry-in.
    csa_ripple_seg #(.W(W0)) u_seg0 (
        .a   (op_a[W0-1:0]),
        .b   (op_b[W0-1:0]),
        .cin (carry_d[0]),
        .s   (sum_d[W0-1:0]),
        .cout(carry_d[1]),
        .cmsb(msb_d[0])
    );

    // Upper slices: dual sums, selected by the carry from below.
    for (genvar g = 1; g < NSEG; g++) begin : g_upper
        localparam int unsigned LO = seg_lo(SEG_W, g);
        localparam int unsigned SW = SEG_W[g];
        csa_select_seg #(.W(SW)) u_seg (
            .a   (op_a[LO +: SW]),
            .b   (op_b[LO +: SW]),
            .sel (carry_d[g]),
            .s   (sum_d[LO +: SW]),
            .cout(carry_d[g+1]),
            .cmsb(msb_d[g])
        );
    end

    assign sum_out        = sum_d;
    assign carry_out      = carry_d[NSEG];
    assign carry_into_msb = msb_d[NSEG-1];
endmodule

// File: rtl/csa_adder_chk.sv
module csa_adder_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             carry_into_msb
);
    logic [WIDTH:0] ref_d;
    logic           sovf_d;

    always_comb begin
        ref_d  = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        sovf_d = (op_a[WIDTH-1] == op_b[WIDTH-1]) && (sum_out[WIDTH-1] != op_a[WIDTH-1]);
    end

    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in})) begin
            assert_full_sum_R1: assert ({carry_out, sum_out} == ref_d)
                else $error("R1 sum mismatch");
            assert_low_nibble_R2: assert (sum_out[3:0] == 4'(op_a[3:0] + op_b[3:0] + {3'b0, carry_in}))
                else $error("R2 low slice mismatch");
            assert_all_ones_R6: assert (!((&op_a) && op_b == '0 && carry_in) || (sum_out == '0 && carry_out))
                else $error("R6 wrap mismatch");
            assert_no_overflow_R7: assert ((carry_into_msb ^ carry_out) == sovf_d)
                else $error("R7 overflow relation broken");
            assert_msb_carry_R7: assert (carry_into_msb == (op_a[WIDTH-1] ^ op_b[WIDTH-1] ^ sum_out[WIDTH-1]))
                else $error("R7 msb carry mismatch");
        end
    end
endmodule

bind csa32_adder csa_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum_out(sum_out), .carry_out(carry_out), .carry_into_msb(carry_into_msb)
);

// File: tb/tb_csa32_adder.sv
`timescale 1ns/1ps
module tb_csa32_adder;
    logic        clk = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [31:0] sum_out;
    logic        carry_out;
    logic        carry_into_msb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    csa32_adder dut (
        .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
        .sum_out(sum_out), .carry_out(carry_out), .carry_into_msb(carry_into_msb)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h cin=%0d)",
                     req, act, exp, op_a, op_b, carry_in);
        end
    endtask

    // Drive on the falling edge, sample a few ns later (R8: same cycle).
    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c);
        logic [32:0] full;
        logic [31:0] low31;
        logic        sov;
        @(negedge clk);
        op_a = a; op_b = b; carry_in = c;
        #2;
        full  = {1'b0, a} + {1'b0, b} + {32'b0, c};
        low31 = {1'b0, a[30:0]} + {1'b0, b[30:0]} + {31'b0, c};
        sov   = (a[31] == b[31]) && (full[31] != a[31]);
        chk("R1", {31'b0, carry_out, sum_out}, {31'b0, full});
        chk("R6", {63'b0, carry_out}, {63'b0, full[32]});
        chk("R7", {62'b0, carry_into_msb, carry_into_msb ^ carry_out}, {62'b0, low31[31], sov});
    endtask

    initial begin
        #20;
        chk("R8 idle zero", {31'b0, carry_out, sum_out}, 64'd0);

        // R2: exhaustive low slice, random upper bits.
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int c = 0; c < 2; c++) begin
                    logic [31:0] ra, rb;
                    logic [4:0]  lo;
                    ra = {$urandom} & 32'hFFFF_FFF0 | 32'(x);
                    rb = {$urandom} & 32'hFFFF_FFF0 | 32'(y);
                    apply(ra, rb, c[0]);
                    lo = 5'(x) + 5'(y) + 5'(c);
                    chk("R2", {60'b0, sum_out[3:0]}, {60'b0, lo[3:0]});
                end

        // Boundary crossings.
        apply(32'h0000_000F, 32'h0, 1'b1);
        chk("R3", {32'b0, sum_out}, 64'h10);
        apply(32'h0000_00FF, 32'h0, 1'b1);
        chk("R4", {32'b0, sum_out}, 64'h100);
        apply(32'h0000_FFFF, 32'h0, 1'b1);
        chk("R5", {32'b0, sum_out}, 64'h1_0000);
        apply(32'hFFFF_FFFF, 32'h0, 1'b1);
        chk("R6 wrap", {31'b0, carry_out, sum_out}, 64'h1_0000_0000);
        apply(32'hFFFF_FFFF, 32'h1, 1'b0);
        chk("R6 wrap b", {31'b0, carry_out, sum_out}, 64'h1_0000_0000);
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        chk("R6 max", {31'b0, carry_out, sum_out}, 64'h1_FFFF_FFFF);

        // R7 sign boundaries.
        apply(32'h7FFF_FFFF, 32'h1, 1'b0);
        chk("R7 pos ovf", {62'b0, carry_into_msb, carry_out}, 64'b10);
        apply(32'h8000_0000, 32'h8000_0000, 1'b0);
        chk("R7 neg ovf", {62'b0, carry_into_msb, carry_out}, 64'b01);
        apply(32'hFFFF_FFFF, 32'h0, 1'b0);
        chk("R7 no ovf", {62'b0, carry_into_msb, carry_out}, 64'b00);

        // Walking runs of ones plus one: carry through every boundary (R3 R4 R5).
        for (int k = 0; k <= 32; k++) begin
            logic [32:0] m;
            m = (33'd1 << k) - 33'd1;
            apply(m[31:0], 32'h1, 1'b0);
            apply(m[31:0], 32'h0, 1'b1);
        end

        // Broad random sweep (R1).
        for (int n = 0; n < 4000; n++)
            apply($urandom, $urandom, 1'($urandom));

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule